// File: doc/BRIEF.md
# Iterative Signed/Unsigned Integer Divider

This block computes a 32-bit quotient over many clock cycles. The caller presents a dividend, a divisor, a mode bit and a 5-bit destination register index, then pulses `start`. The block records the operands and raises `busy`. It spends one cycle conditioning the operands and then thirty-two cycles in a restoring shift-subtract loop, producing one quotient bit per cycle. A final cycle restores the sign and registers the result. `done` then pulses for one cycle and `busy` falls.

In signed mode the loop works on magnitudes. The quotient is negated when the operand signs differ, so it rounds toward zero. The block never traps. A zero divisor, in either mode, is replaced by one. In signed mode the one overflowing pair, most-negative divided by minus one, is also replaced by a divisor of one. In both cases the quotient is the dividend unchanged. A write-enable accompanies `done` only when the destination index is non-zero, because register zero is never written.

Top module: `div_iter_top`

## Requirements
- R1: With `is_signed` = 0 and a non-zero divisor, `quotient` equals floor(dividend / divisor) with both operands read as unsigned.
- R2: With `is_signed` = 1, operands are two's complement and the quotient truncates toward zero (for example, -7 / 2 gives -3 and -7 / -2 gives 3).
- R3: With `is_signed` = 0 and divisor 0, `quotient` equals the dividend.
- R4: With `is_signed` = 1, divisor 0 or the pair dividend 0x80000000 with divisor 0xFFFFFFFF gives `quotient` equal to the dividend.
- R5: A start accepted on clock edge N makes `busy` high from edge N. `done` and the new `quotient` appear after edge N+34, which covers one conditioning cycle, 32 loop cycles and one sign cycle. `busy` is low while `done` is high.
- R6: `done` is high for exactly one cycle per accepted operation.
- R7: A `start` seen while `busy` is high has no effect: the running result is unchanged and no extra `done` follows.
- R8: `wr_en` is high together with `done` exactly when the captured destination index is non-zero, and `wr_idx` equals that captured index.
- R9: After synchronous reset, `busy`, `done` and `wr_en` are low and `quotient` is 0.
- R10: `quotient` changes only in the cycle in which `done` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a division when idle |
| is_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | 32 | Numerator |
| divisor | input | 32 | Denominator |
| dest_idx | input | 5 | Destination register index carried with the operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result pulse |
| quotient | output | 32 | Last result, held until the next one |
| wr_en | output | 1 | Write request for the destination, suppressed for index 0 |
| wr_idx | output | 5 | Destination index of the current or last operation |

## Verification
The assertions assume that `rst` is held for at least one edge before any operation and that the operand inputs are only used at the edge where a start is accepted. After acceptance the block reads only its captured copy, so the properties do not depend on the inputs being stable. The stimulus raises `start` for a single cycle, and only once `busy` is low, except in the deliberate test where it raises `start` during a run. It changes operands freely between operations so that the hold and ignore properties are exercised against moving inputs.

// File: rtl/div_pkg.sv
package div_pkg;
    localparam int DIV_W = 32;
    localparam int IDX_W = 5;
    localparam int CNT_W = $clog2(DIV_W);

    typedef logic [DIV_W-1:0] word_t;
    typedef logic [IDX_W-1:0] idx_t;

    localparam word_t MOST_NEG = {1'b1, {(DIV_W-1){1'b0}}};
    localparam word_t ALL_ONES = {DIV_W{1'b1}};
    localparam word_t ONE_W    = {{(DIV_W-1){1'b0}}, 1'b1};

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PREP,
        PH_LOOP,
        PH_SIGN
    } phase_t;

    // captured operation
    typedef struct packed {
        logic  sgn;
        word_t num;
        word_t den;
        idx_t  dst;
    } op_req_t;

    // conditioned operands fed to the loop
    typedef struct packed {
        word_t num_mag;
        word_t den_mag;
        logic  flip;
    } op_cond_t;

    function automatic word_t negate_w(word_t v);
        return ~v + ONE_W;
    endfunction

    function automatic word_t mag_w(word_t v, logic as_signed);
        return (as_signed && v[DIV_W-1]) ? negate_w(v) : v;
    endfunction
endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
    import div_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output phase_t phase,
    output logic   accept,
    output logic   busy
);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DIV_W - 1);

    phase_t            ph_q;
    logic [CNT_W-1:0]  step_q;

    assign phase  = ph_q;
    assign busy   = (ph_q != PH_IDLE);
    assign accept = (ph_q == PH_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            step_q <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: if (start) ph_q <= PH_PREP;
                PH_PREP: begin
                    ph_q   <= PH_LOOP;
                    step_q <= '0;
                end
                PH_LOOP: begin
                    step_q <= step_q + 1'b1;
                    if (step_q == LAST_STEP) ph_q <= PH_SIGN;
                end
                PH_SIGN: ph_q <= PH_IDLE;
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    // a start during a run must not disturb the sequence
    p_busy_start_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && start && ph_q != PH_SIGN) |=> busy);

    // the loop is entered with the step counter at zero
    p_loop_entry_r5: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_PREP) |=> (ph_q == PH_LOOP && step_q == '0));

    // the sign cycle always returns to idle
    p_sign_to_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_SIGN) |=> (ph_q == PH_IDLE));
endmodule

// File: rtl/div_prep.sv
module div_prep
    import div_pkg::*;
(
    input  op_req_t  req,
    output op_cond_t cond
);
    logic  den_zero;
    logic  overflow_pair;
    logic  use_unit;
    word_t num_abs;
    word_t den_abs;

    always_comb begin
        den_zero      = (req.den == '0);
        overflow_pair = req.sgn && (req.num == MOST_NEG) && (req.den == ALL_ONES);
        use_unit      = den_zero || overflow_pair;
        num_abs       = mag_w(req.num, req.sgn);
        den_abs       = mag_w(req.den, req.sgn);

        cond.num_mag = num_abs;
        cond.den_mag = use_unit ? ONE_W : den_abs;
        // with a unit divisor the result carries the dividend's own sign
        if (!req.sgn)
            cond.flip = 1'b0;
        else if (use_unit)
            cond.flip = req.num[DIV_W-1];
        else
            cond.flip = req.num[DIV_W-1] ^ req.den[DIV_W-1];
    end

    // the loop never sees a zero divisor
    a_den_nonzero_r3: assert final (cond.den_mag != '0);
endmodule

// File: rtl/div_core.sv
module div_core
    import div_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  logic     step,
    input  op_cond_t cond,
    output word_t    q_mag,
    output logic     flip
);
    logic [DIV_W:0] rem_q;
    word_t          quo_q;
    word_t          den_q;
    logic           flip_q;
    logic           armed_q;

    logic [DIV_W:0] shifted;
    logic [DIV_W:0] trial;

    always_comb begin
        shifted = {rem_q[DIV_W-1:0], quo_q[DIV_W-1]};
        trial   = shifted - {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q   <= '0;
            quo_q   <= '0;
            den_q   <= '0;
            flip_q  <= 1'b0;
            armed_q <= 1'b0;
        end else if (load) begin
            rem_q   <= '0;
            quo_q   <= cond.num_mag;
            den_q   <= cond.den_mag;
            flip_q  <= cond.flip;
            armed_q <= 1'b1;
        end else if (step) begin
            if (!trial[DIV_W]) begin
                rem_q <= trial;
                quo_q <= {quo_q[DIV_W-2:0], 1'b1};
            end else begin
                rem_q <= shifted;
                quo_q <= {quo_q[DIV_W-2:0], 1'b0};
            end
        end
    end

    assign q_mag = quo_q;
    assign flip  = flip_q;

    // restoring invariant: partial remainder stays below the divisor
    p_rem_below_den_r1: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> (rem_q < {1'b0, den_q}));
endmodule

// File: rtl/div_iter_top.sv
module div_iter_top
    import div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_signed,
    input  logic [DIV_W-1:0]  dividend,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [IDX_W-1:0]  dest_idx,
    output logic              busy,
    output logic              done,
    output logic [DIV_W-1:0]  quotient,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx
);
    phase_t   phase;
    logic     accept;
    logic     busy_w;
    op_req_t  req_q;
    op_cond_t cond_w;
    word_t    mag_w_s;
    logic     flip_w;
    word_t    quo_q;
    logic     done_q;
    logic     we_q;

    div_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .phase  (phase),
        .accept (accept),
        .busy   (busy_w)
    );

    always_ff @(posedge clk) begin
        if (rst)
            req_q <= '0;
        else if (accept)
            req_q <= {is_signed, dividend, divisor, dest_idx};
    end

    div_prep u_prep (
        .req  (req_q),
        .cond (cond_w)
    );

    div_core u_core (
        .clk   (clk),
        .rst   (rst),
        .load  (phase == PH_PREP),
        .step  (phase == PH_LOOP),
        .cond  (cond_w),
        .q_mag (mag_w_s),
        .flip  (flip_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q  <= '0;
            done_q <= 1'b0;
            we_q   <= 1'b0;
        end else begin
            done_q <= (phase == PH_SIGN);
            we_q   <= (phase == PH_SIGN) && (req_q.dst != '0);
            if (phase == PH_SIGN)
                quo_q <= flip_w ? negate_w(mag_w_s) : mag_w_s;
        end
    end

    assign busy     = busy_w;
    assign done     = done_q;
    assign quotient = quo_q;
    assign wr_en    = we_q;
    assign wr_idx   = req_q.dst;

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_wr_gate_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (done && wr_idx != '0));

    p_q_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(quotient) |-> done);
endmodule

// File: tb/sim_div_iter_top.sv
module sim_div_iter_top;
    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 35; // negedge before accepting edge -> negedge after result edge

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        is_signed = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic [4:0]  dest_idx = '0;
    logic        busy, done, wr_en;
    logic [31:0] quotient;
    logic [4:0]  wr_idx;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    typedef struct {
        logic [31:0] q;
        logic        we;
        logic [4:0]  idx;
        int          stamp;
        string       tag;
    } exp_t;
    exp_t sb[$];
    logic [31:0] last_q = '0;

    div_iter_top u0 (
        .clk(clk), .rst(rst), .start(start), .is_signed(is_signed),
        .dividend(dividend), .divisor(divisor), .dest_idx(dest_idx),
        .busy(busy), .done(done), .quotient(quotient),
        .wr_en(wr_en), .wr_idx(wr_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] model(logic sgn, logic [31:0] a, logic [31:0] b);
        logic signed [31:0] sa, sb_;
        sa = a; sb_ = b;
        if (b == 32'd0) return a;                                   // R3, R4
        if (sgn && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return a; // R4
        if (sgn) return sa / sb_;                                   // R2 truncation
        return a / b;                                               // R1
    endfunction

    task automatic issue(logic sgn, logic [31:0] a, logic [31:0] b, logic [4:0] idx, string tag);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        is_signed = sgn; dividend = a; divisor = b; dest_idx = idx; start = 1'b1;
        e.q = model(sgn, a, b); e.we = (idx != 5'd0); e.idx = idx; e.stamp = cyc; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
        chk("R5 busy after accept", {31'd0, busy}, 32'd1);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R7 unexpected done actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, quotient, e.q);
                chk("R5 latency", cyc - e.stamp, LATENCY);
                chk("R5 busy low with done", {31'd0, busy}, 32'd0);
                chk("R8 wr_en", {31'd0, wr_en}, {31'd0, e.we});
                chk("R8 wr_idx", {27'd0, wr_idx}, {27'd0, e.idx});
                last_q = e.q;
            end
        end
    end

    // R6: done never lasts two cycles
    logic done_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst && done && done_prev) begin
            n_cmp++; n_bad++;
            $display("FAIL R6 done width actual=2 expected=1");
        end
        done_prev = done;
    end

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        chk("R9 busy", {31'd0, busy}, 32'd0);
        chk("R9 done", {31'd0, done}, 32'd0);
        chk("R9 wr_en", {31'd0, wr_en}, 32'd0);
        chk("R9 quotient", quotient, 32'd0);

        // R1 unsigned
        issue(1'b0, 32'd100, 32'd7, 5'd3, "R1 100/7");
        issue(1'b0, 32'hFFFF_FFFF, 32'd1, 5'd4, "R1 max/1");
        issue(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd5, "R1 max/max");
        issue(1'b0, 32'd5, 32'd9, 5'd6, "R1 small/large");
        issue(1'b0, 32'h8000_0000, 32'hFFFF_FFFF, 5'd7, "R1 unsigned not overflow pair");
        // R2 signed truncation
        issue(1'b1, -32'sd7, 32'd2, 5'd8, "R2 -7/2");
        issue(1'b1, 32'd7, -32'sd2, 5'd9, "R2 7/-2");
        issue(1'b1, -32'sd7, -32'sd2, 5'd10, "R2 -7/-2");
        issue(1'b1, 32'h8000_0000, 32'd2, 5'd11, "R2 min/2");
        issue(1'b1, 32'h8000_0000, 32'd1, 5'd12, "R2 min/1");
        // R3, R4 defined corners
        issue(1'b0, 32'd1234, 32'd0, 5'd13, "R3 unsigned zero divisor");
        issue(1'b0, 32'hDEAD_BEEF, 32'd0, 5'd14, "R3 unsigned zero divisor high");
        issue(1'b1, -32'sd5, 32'd0, 5'd15, "R4 signed zero divisor");
        issue(1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 5'd16, "R4 overflow pair");
        // R8 destination zero
        issue(1'b0, 32'd81, 32'd9, 5'd0, "R8 dest zero result");
        drain();

        // R7 start while busy
        issue(1'b0, 32'd1000, 32'd7, 5'd3, "R7 running result");
        repeat (3) @(negedge clk);
        is_signed = 1'b1; dividend = 32'd5; divisor = 32'd1; dest_idx = 5'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7 busy kept", {31'd0, busy}, 32'd1);
        drain();
        repeat (40) @(negedge clk);
        chk("R7 no extra run", {31'd0, busy}, 32'd0);

        // R10 hold with moving inputs, no start
        for (int k = 0; k < 20; k++) begin
            dividend = $urandom; divisor = $urandom; is_signed = k[0];
            @(negedge clk);
        end
        chk("R10 quotient held", quotient, last_q);

        // random mix
        for (int k = 0; k < 150; k++) begin
            logic [31:0] a, b;
            logic s;
            a = $urandom;
            b = $urandom;
            case (k % 4)
                0: b = b & 32'h0000_00FF;
                1: b = b & 32'h0000_FFFF;
                2: a = a & 32'h00FF_FFFF;
                default: ;
            endcase
            s = k[1];
            issue(s, a, b, 5'(k), s ? "R2 random signed" : "R1 random unsigned");
        end
        drain();
        repeat (5) @(negedge clk);
        chk("R10 final hold", quotient, last_q);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule